// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block takes one asynchronous serial line and turns each incoming character into a parallel byte. A two-flop synchroniser conditions the line. A falling edge from the idle level begins a frame. The start bit is then confirmed at its midpoint, using a 16x oversampling enable supplied from outside. Data bits arrive least significant bit first and are sampled at mid-bit. An optional parity bit follows, then one or two stop bits.

Each finished character is judged three ways: stop-bit level, parity, and whether the data register is still unread. A clean character loads the data register and sets the full flag. A character with a framing or parity fault is still loaded, but the full flag does not change. A character that arrives while the register is full raises overrun, and the stored byte is kept. While any error flag is set, no new frame is started. Software clears flags with a write strobe carrying a per-flag mask. Two level interrupt outputs follow the flags whenever interrupts are enabled.

Top module: `async_rx_errlock`

## Requirements
- R1: After reset, `rx_data` is 0, the four flags are 0 and both interrupt outputs are 0.
- R2: A frame begins on a falling edge of the synchronised line and is confirmed at the start bit's midpoint, 8 enables later. If the line is high at that point, the receiver returns to idle and delivers no character.
- R3: In 8-bit mode, data bits are taken least significant bit first, one every 16 enables, and a clean frame loads them unchanged into `rx_data`.
- R4: With `len7` = 1, seven data bits are received, and `rx_data[7]` reads 0.
- R5: With `par_en` = 1, the count of ones over the data bits plus the parity bit must be even when `par_odd` = 0 and odd when `par_odd` = 1. A mismatch sets `par_err` and still loads `rx_data`, and `rx_full` keeps its previous value.
- R6: A first stop bit sampled as 0 sets `frm_err` and still loads `rx_data`, and `rx_full` keeps its previous value.
- R7: With `stop2` = 1, only the first stop bit is checked. A 0 in the second stop bit causes no error.
- R8: A character that completes while `rx_full` = 1 sets `ovr_err`, and `rx_data` keeps the older byte.
- R9: A character with no fault, arriving while `rx_full` = 0, loads `rx_data` and sets `rx_full`.
- R10: `irq_rx` = `rx_ie` AND `rx_full`. `irq_err` = `rx_ie` AND (`ovr_err` OR `frm_err` OR `par_err`).
- R11: While any of `ovr_err`, `frm_err` or `par_err` is 1, incoming frames are ignored and `rx_data` does not change.
- R12: A cycle with `clr_we` = 1 clears each flag whose mask bit is 1. The mask bits are: bit 0 `rx_full`, bit 1 `ovr_err`, bit 2 `frm_err`, bit 3 `par_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Asynchronous serial line, idle high |
| len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | Two stop bits |
| rx_ie | input | 1 | Receive interrupt enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flags to clear (see R12) |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Data register full |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing flag |
| par_err | output | 1 | Parity flag |
| irq_rx | output | 1 | Receive-data interrupt request (level) |
| irq_err | output | 1 | Error interrupt request (level) |

## Verification
The bench sends every 8-bit value with no parity, and every 7-bit value with parity. The parity sense alternates between values, so a receiver that reversed the bit order, miscounted ones or leaked a bit into `rx_data[7]` would return wrong bytes. It also injects bad parity, a low stop bit and a low second stop bit. A design that dropped faulty data, or set `rx_full` on a faulty character, would fail these checks, and so would one that checked both stop bits. Further checks cover an overrun with the older byte kept and a frame sent during error lockout, which a receiver without lockout would load. A glitch that fails start-bit confirmation must leave the receiver idle and ready for the next real frame.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int DW  = 8;
    localparam int OVS = 16;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
    } rx_state_t;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic stop2;
    } rx_mode_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          frm_bad;
        logic          par_bad;
    } rx_result_t;

    function automatic logic ones_odd(input logic [DW-1:0] d, input logic p);
        return (^d) ^ p;
    endfunction
endpackage

// File: rtl/arx_sync.sv
module arx_sync (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic s1;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            dout <= 1'b1;
        end else begin
            s1   <= din;
            dout <= s1;
        end
    end
endmodule

// File: rtl/arx_framer.sv
module arx_framer
    import arx_pkg::*;
#(
    parameter int OV = OVS,
    parameter int W  = DW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic       lock_i,
    input  rx_mode_t   mode,
    output logic       done_o,
    output rx_result_t res_o
);
    localparam int CW   = $clog2(OV);
    localparam int BW   = $clog2(W);
    localparam int HALF = OV / 2;

    rx_state_t     st;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [W-1:0]  sr;
    logic          pbit;
    logic          line_prev;
    logic          frm_bad_q;
    logic          at_mid;
    logic [BW-1:0] last_bit;
    logic [W-1:0]  data_c;

    assign at_mid   = tick && (cnt == CW'(OV - 1));
    assign last_bit = mode.len7 ? BW'(W - 2) : BW'(W - 1);
    assign data_c   = mode.len7 ? {1'b0, sr[W-1:1]} : sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            sr        <= '0;
            pbit      <= 1'b0;
            line_prev <= 1'b1;
            done_o    <= 1'b0;
            frm_bad_q <= 1'b0;
        end else begin
            line_prev <= line;
            done_o    <= 1'b0;
            if (st != ST_IDLE && tick)
                cnt <= at_mid ? '0 : cnt + 1'b1;
            case (st)
                ST_IDLE: if (!lock_i && line_prev && !line) begin
                    st  <= ST_START;
                    cnt <= '0;
                end
                ST_START: if (tick && cnt == CW'(HALF - 1)) begin
                    cnt  <= '0;
                    bitn <= '0;
                    st   <= line ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (at_mid) begin
                    sr <= {line, sr[W-1:1]};
                    if (bitn == last_bit)
                        st <= mode.par_en ? ST_PAR : ST_STOP;
                    else
                        bitn <= bitn + 1'b1;
                end
                ST_PAR: if (at_mid) begin
                    pbit <= line;
                    st   <= ST_STOP;
                end
                ST_STOP: if (at_mid) begin
                    done_o    <= 1'b1;
                    frm_bad_q <= !line;
                    st        <= mode.stop2 ? ST_STOP2 : ST_IDLE;
                end
                ST_STOP2: if (at_mid) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        res_o.data    = data_c;
        res_o.frm_bad = frm_bad_q;
        res_o.par_bad = mode.par_en && (ones_odd(data_c, pbit) != mode.par_odd);
    end

    AST_NO_START_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && lock_i) |=> (st == ST_IDLE)) else $error("lockout start"); // R11
endmodule

// File: rtl/arx_flags.sv
module arx_flags
    import arx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          done_i,
    input  rx_result_t    res_i,
    input  logic          clr_we,
    input  logic [3:0]    clr_mask,
    input  logic          ie,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          ovr,
    output logic          frm,
    output logic          par,
    output logic          lock_o,
    output logic          irq_rx,
    output logic          irq_err
);
    logic bad;
    assign bad     = res_i.frm_bad || res_i.par_bad;
    assign lock_o  = ovr || frm || par;
    assign irq_rx  = ie && full;
    assign irq_err = ie && lock_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            full  <= 1'b0;
            ovr   <= 1'b0;
            frm   <= 1'b0;
            par   <= 1'b0;
        end else begin
            if (clr_we) begin
                if (clr_mask[0]) full <= 1'b0;
                if (clr_mask[1]) ovr  <= 1'b0;
                if (clr_mask[2]) frm  <= 1'b0;
                if (clr_mask[3]) par  <= 1'b0;
            end
            if (done_i) begin
                if (res_i.frm_bad) frm <= 1'b1;
                if (res_i.par_bad) par <= 1'b1;
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    rdata <= res_i.data;
                    if (!bad) full <= 1'b1;
                end
            end
        end
    end

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (done_i && full) |=> (ovr && $stable(rdata))) else $error("overrun"); // R8
    AST_ERR_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
        (done_i && !full && bad && !clr_we) |=> (!full && rdata == $past(res_i.data))) else $error("err load"); // R5
    AST_FRM_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done_i && res_i.frm_bad) |=> frm) else $error("framing"); // R6
    AST_CLEAN_LOAD: assert property (@(posedge clk) disable iff (rst)
        (done_i && !full && !bad) |=> (full && rdata == $past(res_i.data))) else $error("clean load"); // R9
endmodule

// File: rtl/async_rx_errlock.sv
module async_rx_errlock
    import arx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       len7,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       stop2,
    input  logic       rx_ie,
    input  logic       clr_we,
    input  logic [3:0] clr_mask,
    output logic [7:0] rx_data,
    output logic       rx_full,
    output logic       ovr_err,
    output logic       frm_err,
    output logic       par_err,
    output logic       irq_rx,
    output logic       irq_err
);
    logic       line;
    logic       done;
    logic       lock;
    rx_mode_t   mode;
    rx_result_t res;

    assign mode = '{len7: len7, par_en: par_en, par_odd: par_odd, stop2: stop2};

    arx_sync u_sync (.clk(clk), .rst(rst), .din(rxd), .dout(line));

    arx_framer #(.OV(OVS), .W(DW)) u_framer (
        .clk(clk), .rst(rst), .tick(os_tick), .line(line), .lock_i(lock),
        .mode(mode), .done_o(done), .res_o(res)
    );

    arx_flags u_flags (
        .clk(clk), .rst(rst), .done_i(done), .res_i(res), .clr_we(clr_we),
        .clr_mask(clr_mask), .ie(rx_ie), .rdata(rx_data), .full(rx_full),
        .ovr(ovr_err), .frm(frm_err), .par(par_err), .lock_o(lock),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );
endmodule

// File: tb/tb_async_rx_errlock.sv
`timescale 1ns/1ps
module tb_async_rx_errlock;
    localparam int BT = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b1;
    logic rxd = 1'b1;
    logic len7 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, rx_ie = 1'b1;
    logic clr_we = 1'b0;
    logic [3:0] clr_mask = 4'h0;
    logic [7:0] rx_data;
    logic rx_full, ovr_err, frm_err, par_err, irq_rx, irq_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    async_rx_errlock dut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .len7(len7),
        .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .rx_ie(rx_ie),
        .clr_we(clr_we), .clr_mask(clr_mask), .rx_data(rx_data), .rx_full(rx_full),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic par_bit(input logic [7:0] d, input int nb, input logic odd);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += d[i];
        return (ones % 2 == 1) ? !odd : odd;
    endfunction

    task automatic wait_bit();
        repeat (BT) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic pen, input logic pv,
                        input logic s1, input logic s2en, input logic s2v);
        rxd = 1'b0; wait_bit();
        for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_bit(); end
        if (pen) begin rxd = pv; wait_bit(); end
        rxd = s1; wait_bit();
        if (s2en) begin rxd = s2v; wait_bit(); end
        rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic clear(input logic [3:0] m);
        @(negedge clk); clr_we = 1'b1; clr_mask = m;
        @(negedge clk); clr_we = 1'b0; clr_mask = 4'h0;
    endtask

    function automatic int flags();
        return {28'd0, par_err, frm_err, ovr_err, rx_full};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data", rx_data, 0);
        check("R1 flags", flags(), 0);
        check("R1 irq", {irq_rx, irq_err}, 0);

        // R3 R9 R10: exhaustive 8-bit, no parity
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 8, 0, 0, 1, 0, 0);
            check("R3 data", rx_data, v);
            check("R9 full", flags(), 1);
            check("R10 irq_rx", {irq_rx, irq_err}, 2);
            clear(4'b0001);
        end
        check("R12 full cleared", flags(), 0);

        // R4 R5: exhaustive 7-bit with parity, sense alternating
        len7 = 1; par_en = 1;
        for (int v = 0; v < 128; v++) begin
            par_odd = v[0];
            send(8'(v), 7, 1, par_bit(8'(v), 7, v[0]), 1, 0, 0);
            check("R4 data", rx_data, v);
            check("R5 good parity flags", flags(), 1);
            clear(4'b0001);
        end

        // R5 bad parity: data loaded, full unchanged, error irq
        par_odd = 0;
        send(8'h5A, 7, 1, !par_bit(8'h5A, 7, 0), 1, 0, 0);
        check("R5 bad parity data", rx_data, 8'h5A);
        check("R5 bad parity flags", flags(), 8);
        check("R10 irq_err", {irq_rx, irq_err}, 1);

        // R11 lockout while par_err set
        send(8'h11, 7, 1, par_bit(8'h11, 7, 0), 1, 0, 0);
        check("R11 locked data", rx_data, 8'h5A);
        check("R11 locked flags", flags(), 8);
        clear(4'b1000);
        check("R12 par cleared", flags(), 0);
        send(8'h33, 7, 1, par_bit(8'h33, 7, 0), 1, 0, 0);
        check("R11 resumed data", rx_data, 8'h33);
        check("R11 resumed flags", flags(), 1);
        clear(4'b0001);

        // R6 framing error, 8-bit no parity
        len7 = 0; par_en = 0;
        send(8'hC3, 8, 0, 0, 0, 0, 0);
        check("R6 framing data", rx_data, 8'hC3);
        check("R6 framing flags", flags(), 4);
        clear(4'b0100);

        // R8 overrun
        send(8'hA5, 8, 0, 0, 1, 0, 0);
        send(8'h3C, 8, 0, 0, 1, 0, 0);
        check("R8 overrun data", rx_data, 8'hA5);
        check("R8 overrun flags", flags(), 3);
        clear(4'b1111);
        check("R12 all cleared", flags(), 0);

        // R7 two stop bits
        stop2 = 1;
        send(8'h96, 8, 0, 0, 1, 1, 0);
        check("R7 second stop ignored data", rx_data, 8'h96);
        check("R7 second stop ignored flags", flags(), 1);
        clear(4'b0001);
        send(8'h69, 8, 0, 0, 0, 1, 1);
        check("R7 first stop checked", flags(), 4);
        check("R7 first stop data", rx_data, 8'h69);
        clear(4'b0100);
        stop2 = 0;

        // R2 false start
        rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R2 false start flags", flags(), 0);
        check("R2 false start data", rx_data, 8'h69);
        send(8'h7E, 8, 0, 0, 1, 0, 0);
        check("R2 after glitch data", rx_data, 8'h7E);

        // R10 interrupts masked
        rx_ie = 0;
        @(negedge clk);
        check("R10 masked irq", {irq_rx, irq_err}, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule